// File: doc/BRIEF.md
# USB IN Endpoint Bank Controller

This block owns the transmit buffer of a single USB device IN endpoint. It sits between a processor-side register port and a simplified USB packet engine. Firmware loads a payload one byte at a time and then raises a packet-ready flag. Raising the flag hands the loaded bank to the USB side. When the packet engine reports an IN token, the block answers on the next cycle. If a bank is ready, it offers that bank's payload, with its length, through a byte-read stream. If no bank is ready, it signals a NAK.

Once the host acknowledges the packet, hardware clears the bank's ready flag and sets a completion flag. The endpoint interrupt follows the completion flag and drops only when firmware clears it. If the host does not acknowledge, the bank stays ready and the same data is offered again on the next token.

In two-bank mode the processor fills one bank while the USB side holds the other. The USB side drains banks strictly in turn, starting from bank 0. The mode pin is sampled continuously and is expected to change only while both banks are empty.

Top module: `usb_in_bank_ctrl`

## Requirements
- R1: After reset `sts_pktrdy`, `sts_comp`, `irq`, `usb_busy`, `usb_send` and `usb_nak` are all 0.
- R2: Bytes written with `cpu_wr_en` are stored in order. The length presented on `usb_len` equals the number of bytes written before `cpu_set_ready`. During a transfer, `usb_rd_data` shows byte 0 first and then advances by one byte per `usb_rd_en` cycle.
- R3: Byte writes made while `sts_pktrdy` is 1 are ignored. They change neither the length nor the data of the ready packet.
- R4: A bank holds at most MAX_PKT bytes (64 by default). Writes beyond that limit are ignored, so `usb_len` never exceeds MAX_PKT.
- R5: Setting packet-ready with no bytes written makes a zero-length packet, which is offered with `usb_len` = 0.
- R6: An IN token that arrives while idle, when the next bank to send is not ready, gives a one-cycle `usb_nak` on the following cycle and no `usb_send`.
- R7: An IN token that arrives while idle, when the next bank to send is ready, gives a one-cycle `usb_send` on the following cycle. `usb_busy` then stays 1 until `usb_ack` or `usb_noack`.
- R8: `usb_ack` during a transfer sets `sts_comp` and `irq` on the next cycle, and clears that bank's ready flag.
- R9: `usb_noack` during a transfer ends it without setting `sts_comp`. The bank stays ready, and the next token offers the same payload again from byte 0.
- R10: `sts_comp` and `irq` stay 1 until a `cpu_clr_comp` pulse. A clear in the same cycle as an accepted ACK leaves them at 1.
- R11: With `cfg_pingpong` = 1, each accepted packet-ready moves the processor to the other bank, and the USB side sends banks alternately from bank 0. A bank can be loaded and marked ready while the other bank is being sent. `sts_pktrdy` shows the flag of the bank the processor would write next.
- R12: Packet-ready for the next packet may be set while `sts_comp` is still 1 from the previous packet. Both the new packet and the pending completion are kept.
- R13: With `cfg_pingpong` = 0, only one bank is used. `sts_pktrdy` stays 1 from packet-ready until the ACK of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pingpong | input | 1 | 1 selects two-bank operation |
| cpu_wr_en | input | 1 | Write one payload byte |
| cpu_wr_data | input | 8 | Payload byte |
| cpu_set_ready | input | 1 | Pulse: mark the current processor bank ready |
| cpu_clr_comp | input | 1 | Pulse: clear the completion flag |
| sts_pktrdy | output | 1 | Ready flag of the processor's current bank |
| sts_comp | output | 1 | Completion flag |
| irq | output | 1 | Endpoint interrupt |
| usb_in_tok | input | 1 | Pulse: IN token received |
| usb_rd_en | input | 1 | Advance to the next payload byte |
| usb_ack | input | 1 | Pulse: host acknowledged the packet |
| usb_noack | input | 1 | Pulse: no acknowledge (timeout) |
| usb_send | output | 1 | Pulse: a payload is offered |
| usb_nak | output | 1 | Pulse: answer the token with NAK |
| usb_busy | output | 1 | Transfer in progress |
| usb_len | output | 7 | Payload length of the bank being sent |
| usb_rd_data | output | 8 | Current payload byte |

## Verification
All control results are registered, so each appears one cycle after its cause. `usb_send` or `usb_nak` follows a token by one cycle. `sts_comp`, `irq` and the cleared ready flag follow an ACK by one cycle. `sts_pktrdy` follows packet-ready by one cycle, and each byte advance follows a `usb_rd_en` cycle by one cycle. `usb_len` and `usb_rd_data` are combinational views of the selected bank, and they are valid once `usb_send` has been seen. The bench drives every input on the falling edge and samples on the next falling edge. Each check therefore falls exactly one rising edge after its stimulus.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;

  // Bank the pointer moves to after a handoff; single-bank mode stays on bank 0.
  function automatic logic bank_after(input logic cur, input logic pingpong);
    return pingpong ? ~cur : 1'b0;
  endfunction

  // Whether another byte still fits in a bank that already holds fill bytes.
  function automatic logic has_room(input int fill, input int max_bytes);
    return fill < max_bytes;
  endfunction

endpackage

// File: rtl/usb_in_bank.sv
module usb_in_bank #(
  parameter int MAX_PKT = 64,
  localparam int AW = $clog2(MAX_PKT),
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          set_rdy,
  input  logic          clr_rdy,
  input  logic [AW-1:0] rd_idx,
  output logic          rdy,
  output logic [CW-1:0] len,
  output logic [7:0]    rd_data
);
  import usb_in_pkg::*;

  logic [7:0]    mem [MAX_PKT];
  logic [CW-1:0] fill;
  logic          set_take;
  logic          wr_take;

  assign set_take = set_rdy && !rdy;
  assign wr_take  = wr_en && !rdy && !set_rdy && has_room(int'(fill), MAX_PKT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      len  <= '0;
      fill <= '0;
    end else begin
      if (set_take) begin
        rdy  <= 1'b1;
        len  <= fill;
        fill <= '0;
      end else if (wr_take) begin
        fill <= fill + 1'b1;
      end
      if (clr_rdy) rdy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_take) mem[fill[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/usb_in_tx_ctrl.sv
module usb_in_tx_ctrl #(
  parameter int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok,
  input  logic          rd_en,
  input  logic          ack,
  input  logic          noack,
  input  logic          bank_rdy,
  input  logic [CW-1:0] bank_len,
  output logic          busy,
  output logic          send,
  output logic          nak,
  output logic [CW-1:0] rd_ptr,
  output logic          ack_take,
  output logic          noack_take
);

  assign ack_take   = busy && ack;
  assign noack_take = busy && !ack && noack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      send   <= 1'b0;
      nak    <= 1'b0;
      rd_ptr <= '0;
    end else begin
      send <= 1'b0;
      nak  <= 1'b0;
      if (!busy) begin
        if (tok) begin
          if (bank_rdy) begin
            send   <= 1'b1;
            busy   <= 1'b1;
            rd_ptr <= '0;
          end else begin
            nak <= 1'b1;
          end
        end
      end else if (ack_take || noack_take) begin
        busy   <= 1'b0;
        rd_ptr <= '0;
      end else if (rd_en && rd_ptr < bank_len) begin
        rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/usb_in_bank_ctrl.sv
module usb_in_bank_ctrl #(
  parameter int MAX_PKT = 64,
  localparam int NB = 2,
  localparam int AW = $clog2(MAX_PKT),
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_pingpong,
  input  logic          cpu_wr_en,
  input  logic [7:0]    cpu_wr_data,
  input  logic          cpu_set_ready,
  input  logic          cpu_clr_comp,
  output logic          sts_pktrdy,
  output logic          sts_comp,
  output logic          irq,
  input  logic          usb_in_tok,
  input  logic          usb_rd_en,
  input  logic          usb_ack,
  input  logic          usb_noack,
  output logic          usb_send,
  output logic          usb_nak,
  output logic          usb_busy,
  output logic [CW-1:0] usb_len,
  output logic [7:0]    usb_rd_data
);
  import usb_in_pkg::*;

  logic          wr_bank;
  logic          tx_bank;
  logic [NB-1:0] rdy_v;
  logic [CW-1:0] len_v  [NB];
  logic [7:0]    data_v [NB];
  logic [CW-1:0] rd_ptr;
  logic          ev_set_take;
  logic          ev_ack_take;
  logic          ev_noack_take;
  logic          comp_q;

  assign ev_set_take = cpu_set_ready && !rdy_v[wr_bank];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    usb_in_bank #(.MAX_PKT(MAX_PKT)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cpu_wr_en && (wr_bank == 1'(b))),
      .wr_data (cpu_wr_data),
      .set_rdy (cpu_set_ready && (wr_bank == 1'(b))),
      .clr_rdy (ev_ack_take && (tx_bank == 1'(b))),
      .rd_idx  (rd_ptr[AW-1:0]),
      .rdy     (rdy_v[b]),
      .len     (len_v[b]),
      .rd_data (data_v[b])
    );
  end

  usb_in_tx_ctrl #(.MAX_PKT(MAX_PKT)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok        (usb_in_tok),
    .rd_en      (usb_rd_en),
    .ack        (usb_ack),
    .noack      (usb_noack),
    .bank_rdy   (rdy_v[tx_bank]),
    .bank_len   (len_v[tx_bank]),
    .busy       (usb_busy),
    .send       (usb_send),
    .nak        (usb_nak),
    .rd_ptr     (rd_ptr),
    .ack_take   (ev_ack_take),
    .noack_take (ev_noack_take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank <= 1'b0;
      tx_bank <= 1'b0;
      comp_q  <= 1'b0;
    end else begin
      if (ev_set_take) wr_bank <= bank_after(wr_bank, cfg_pingpong);
      if (ev_ack_take) tx_bank <= bank_after(tx_bank, cfg_pingpong);
      if (ev_ack_take)       comp_q <= 1'b1;
      else if (cpu_clr_comp) comp_q <= 1'b0;
    end
  end

  assign sts_pktrdy  = rdy_v[wr_bank];
  assign sts_comp    = comp_q;
  assign irq         = comp_q;
  assign usb_len     = len_v[tx_bank];
  assign usb_rd_data = data_v[tx_bank];

endmodule

// File: rtl/usb_in_bank_ctrl_chk.sv
module usb_in_bank_ctrl_chk #(
  parameter int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_pingpong,
  input logic          cpu_clr_comp,
  input logic          usb_in_tok,
  input logic          usb_ack,
  input logic          usb_noack,
  input logic          usb_send,
  input logic          usb_nak,
  input logic          usb_busy,
  input logic [CW-1:0] usb_len,
  input logic          sts_comp,
  input logic          sts_pktrdy,
  input logic          ev_ack_take,
  input logic          ev_noack_take
);

  p_send_nak_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(usb_send && usb_nak));

  p_nak_after_tok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    usb_nak |-> ($past(usb_in_tok) && !$past(usb_busy)));

  p_send_after_tok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    usb_send |-> ($past(usb_in_tok) && usb_busy));

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(usb_busy) |-> $past(usb_ack || usb_noack));

  p_comp_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_take |=> sts_comp);

  p_comp_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_comp) |-> $past(ev_ack_take));

  p_comp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_comp && !cpu_clr_comp) |=> sts_comp);

  p_retry_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_noack_take && !cfg_pingpong) |=> sts_pktrdy);

  p_len_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    usb_len <= CW'(MAX_PKT));

endmodule

bind usb_in_bank_ctrl usb_in_bank_ctrl_chk #(.MAX_PKT(MAX_PKT)) u_chk (.*);

// File: tb/usb_in_bank_ctrl_test.sv
module usb_in_bank_ctrl_test;
  localparam int MAX_PKT = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_pingpong = 1'b0;
  logic       cpu_wr_en = 1'b0;
  logic [7:0] cpu_wr_data = '0;
  logic       cpu_set_ready = 1'b0;
  logic       cpu_clr_comp = 1'b0;
  logic       usb_in_tok = 1'b0;
  logic       usb_rd_en = 1'b0;
  logic       usb_ack = 1'b0;
  logic       usb_noack = 1'b0;
  logic       sts_pktrdy, sts_comp, irq;
  logic       usb_send, usb_nak, usb_busy;
  logic [6:0] usb_len;
  logic [7:0] usb_rd_data;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  usb_in_bank_ctrl #(.MAX_PKT(MAX_PKT)) uut (.*);

  function automatic logic [7:0] pkt_byte(input int id, input int idx);
    return 8'((id * 37) + (idx * 11) + 5);
  endfunction

  function automatic int exp_len(input int n);
    return (n > MAX_PKT) ? MAX_PKT : n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic pp);
    rst_n = 1'b0;
    cfg_pingpong = pp;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic write_pkt(input int id, input int n);
    for (int i = 0; i < n; i++) begin
      cpu_wr_en = 1'b1;
      cpu_wr_data = pkt_byte(id, i);
      tick();
    end
    cpu_wr_en = 1'b0;
  endtask

  task automatic set_ready();
    cpu_set_ready = 1'b1;
    tick();
    cpu_set_ready = 1'b0;
  endtask

  task automatic clr_comp();
    cpu_clr_comp = 1'b1;
    tick();
    cpu_clr_comp = 1'b0;
  endtask

  task automatic token(output logic s, output logic k);
    usb_in_tok = 1'b1;
    tick();
    usb_in_tok = 1'b0;
    s = usb_send;
    k = usb_nak;
  endtask

  // Read the offered payload and compare it; end with the chosen handshake.
  // kind: 0 no-ACK, 1 ACK, 2 ACK together with a completion clear.
  task automatic read_pkt(input string req, input int id, input int n, input int kind);
    check({req, " len"}, int'(usb_len), n);
    check({req, " busy"}, int'(usb_busy), 1);
    for (int i = 0; i < n; i++) begin
      check({req, " data"}, int'(usb_rd_data), int'(pkt_byte(id, i)));
      usb_rd_en = 1'b1;
      tick();
      usb_rd_en = 1'b0;
    end
    usb_ack      = (kind != 0);
    usb_noack    = (kind == 0);
    cpu_clr_comp = (kind == 2);
    tick();
    usb_ack = 1'b0; usb_noack = 1'b0; cpu_clr_comp = 1'b0;
    check({req, " busy end"}, int'(usb_busy), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic s, k;
    int q_id [2];
    int q_len [2];
    int head, pending, next_id, n;
    bit exp_comp;
    void'($urandom(32'd20240611));

    // ---------------- single-bank mode ----------------
    do_reset(1'b0);
    check("R1 pktrdy", int'(sts_pktrdy), 0);
    check("R1 comp", int'(sts_comp), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 busy", int'(usb_busy), 0);
    check("R1 send", int'(usb_send), 0);
    check("R1 nak", int'(usb_nak), 0);

    token(s, k);
    check("R6 nak", int'(k), 1);
    check("R6 no send", int'(s), 0);
    tick();
    check("R6 nak one cycle", int'(usb_nak), 0);

    write_pkt(1, 5);
    set_ready();
    check("R13 pktrdy set", int'(sts_pktrdy), 1);
    write_pkt(9, 3);                        // R3: ignored while ready
    check("R13 pktrdy held", int'(sts_pktrdy), 1);
    token(s, k);
    check("R7 send", int'(s), 1);
    check("R7 no nak", int'(k), 0);
    tick();
    check("R7 send one cycle", int'(usb_send), 0);
    read_pkt("R3 R2 first try", 1, 5, 0);   // R9: no ACK
    check("R9 comp clear", int'(sts_comp), 0);
    check("R9 still ready", int'(sts_pktrdy), 1);
    token(s, k);
    check("R9 resend", int'(s), 1);
    read_pkt("R9 resend data", 1, 5, 1);
    check("R8 comp", int'(sts_comp), 1);
    check("R8 irq", int'(irq), 1);
    check("R13 pktrdy cleared", int'(sts_pktrdy), 0);

    for (int i = 0; i < 5; i++) tick();
    check("R10 comp holds", int'(sts_comp), 1);

    set_ready();                            // R5 zero length, R12 while comp set
    check("R12 ready with comp", int'(sts_pktrdy), 1);
    check("R12 comp kept", int'(sts_comp), 1);
    token(s, k);
    check("R5 send", int'(s), 1);
    read_pkt("R5 zlp", 2, 0, 2);
    check("R10 ack beats clear", int'(sts_comp), 1);
    clr_comp();
    check("R10 cleared", int'(sts_comp), 0);
    check("R10 irq cleared", int'(irq), 0);

    write_pkt(3, 70);
    set_ready();
    token(s, k);
    check("R4 send", int'(s), 1);
    read_pkt("R4 saturate", 3, MAX_PKT, 1);
    clr_comp();

    // ---------------- two-bank mode ----------------
    do_reset(1'b1);
    write_pkt(4, 4);
    set_ready();
    check("R11 other bank free", int'(sts_pktrdy), 0);
    token(s, k);
    check("R11 send bank0", int'(s), 1);
    write_pkt(5, 3);                        // fill bank 1 during transfer
    set_ready();
    check("R11 both ready", int'(sts_pktrdy), 1);
    read_pkt("R11 bank0 data", 4, 4, 1);
    check("R11 bank0 freed", int'(sts_pktrdy), 0);
    token(s, k);
    check("R11 send bank1", int'(s), 1);
    read_pkt("R11 bank1 data", 5, 3, 1);
    token(s, k);
    check("R11 nak when empty", int'(k), 1);
    clr_comp();

    // ---------------- random two-bank traffic ----------------
    head = 0; pending = 0; next_id = 10; exp_comp = 1'b0;
    for (int it = 0; it < 120; it++) begin
      check("R11 pktrdy model", int'(sts_pktrdy), (pending == 2) ? 1 : 0);
      check("R10 comp model", int'(sts_comp), int'(exp_comp));
      if (pending < 2 && ($urandom % 2) == 1) begin
        n = ($urandom % 8 == 0) ? MAX_PKT + 2 : int'($urandom % (MAX_PKT + 1));
        write_pkt(next_id, n);
        set_ready();
        q_id[(head + pending) % 2]  = next_id;
        q_len[(head + pending) % 2] = exp_len(n);
        pending++;
        next_id++;
      end else begin
        token(s, k);
        if (pending == 0) begin
          check("R6 random nak", int'(k), 1);
        end else begin
          check("R7 random send", int'(s), 1);
          if ($urandom % 4 == 0) begin
            read_pkt("R9 random retry", q_id[head], q_len[head], 0);
          end else begin
            read_pkt("R2 random data", q_id[head], q_len[head], 1);
            exp_comp = 1'b1;
            head = (head + 1) % 2;
            pending--;
          end
        end
      end
      if (exp_comp && ($urandom % 3 == 0)) begin
        clr_comp();
        exp_comp = 1'b0;
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule